// File: doc/BRIEF.md
# Pixel Sampling Pulse Generator

This block derives the two internal sample pulses of an image-sensor front end from the main clock and the per-pixel timing strobe. The first is the data-level pulse, whose falling edge is the point where the signal level is held. The second is the feed-through pulse, which is used in correlated double sampling to hold the reset level and to close the clamp switch. The block runs on a fast clock at twice the main-clock rate. An input flag marks each fast-clock edge that coincides with a main-clock rising edge. Using that flag, the block can place edges in whole or half main-clock steps.

The strobe is sampled only on main-clock rising edges. The first such edge that sees the strobe low, after one or more edges that saw it high, is the reference edge, and the data-level pulse falls there. The rising edge of the data-level pulse comes before the reference edge can be known. The block therefore places it from the nominal pixel period: 16 fast cycles in single-edge mode and 8 in double-edge mode, counted from the previous reference edge. The feed-through pulse is placed a programmable delay after the reference edge. The block also gives a one-cycle pixel-start strobe for a downstream serializer, and an error flag that is raised when the strobe covers more main-clock edges than the clock mode allows.

Top module: `pixel_sample_pulse_gen`

## Requirements
- R1: In synchronous mode (`cfg_direct`=0), the reference edge is the first fast-clock edge with `mclk_rise`=1 and `strobe`=0 after at least one edge with `mclk_rise`=1 and `strobe`=1. `dl_pulse` is low from the cycle after that edge.
- R2: In single-edge mode (`cfg_dbl`=0) and synchronous mode, `dl_pulse` is high for 2*(`cfg_width`+1) fast cycles before it falls, that is 1 to 4 main periods. Its rise is placed 16 fast cycles after the previous reference edge minus that width.
- R3: In double-edge mode (`cfg_dbl`=1) and synchronous mode, `dl_pulse` is high for `cfg_width`+1 fast cycles (half-period steps) before it falls. The nominal pixel period is 8 fast cycles.
- R4: With `cfg_direct`=1, `dl_pulse` equals `strobe` combinationally, and `cfg_width` has no effect.
- R5: In single-edge CDS mode, `ft_pulse` is high for 2 fast cycles and falls 2*(`cfg_ftpos`+2) fast cycles after the reference edge. It is therefore high in the cycles 2*`cfg_ftpos`+2 and 2*`cfg_ftpos`+3 after that edge.
- R6: In double-edge CDS mode, `ft_pulse` is high for 1 fast cycle and falls `cfg_ftpos`+2 fast cycles after the reference edge. It is therefore high in the cycle `cfg_ftpos`+1 after that edge.
- R7: With `cfg_cds`=0 (DC mode), `ft_pulse` stays low.
- R8: At a reference edge, a high-edge count of 4 or more in single-edge mode, or 2 or more in double-edge mode, raises `err_flag` for one pixel period: 16 or 8 fast cycles. A legal count at the next reference edge clears it.
- R9: `pix_start` is high for exactly the one cycle after each reference edge, in both sampling modes.
- R10: During reset all outputs are low, and before the first reference edge after reset `dl_pulse` (synchronous mode) and `ft_pulse` stay low.
- R11: If no reference edge arrives at the nominal time, a risen `dl_pulse` stays high until the next reference edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock at twice the main-clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclk_rise | input | 1 | High on fast edges that coincide with a main-clock rising edge |
| strobe | input | 1 | Pixel timing strobe |
| cfg_dbl | input | 1 | 0 single-edge, 1 double-edge clock mode |
| cfg_cds | input | 1 | 0 DC-coupled input, 1 CDS input |
| cfg_direct | input | 1 | 0 synchronous sampling, 1 strobe used as data-level pulse |
| cfg_width | input | 2 | Data-level pulse width code |
| cfg_ftpos | input | 2 | Feed-through pulse position code |
| dl_pulse | output | 1 | Data-level sample pulse |
| ft_pulse | output | 1 | Feed-through sample and clamp pulse |
| pix_start | output | 1 | One-cycle pixel-start strobe |
| err_flag | output | 1 | Strobe edge-count violation flag |

## Verification
At a reference edge, `pix_start`, the fall of `dl_pulse` and the setting or clearing of `err_flag` all happen in the same cycle. The bench provokes this with strobes that cover four single-edge or two double-edge main-clock edges. It then checks on each cycle that the flag rises in the same cycle as the pixel-start strobe and holds for exactly one pixel period. The feed-through pulse can also overlap the data-level pulse: with the widest width code and the latest position code in CDS mode, both are high in the same cycles. The bench checks each of them, cycle by cycle, against its own expected window.

// File: rtl/pixel_sample_pulse_gen.sv
`timescale 1ns/1ps
module pixel_sample_pulse_gen #(
  parameter int PIX_SGL = 16,
  parameter int PIX_DBL = 8,
  parameter int CNT_W   = 3,
  parameter int CTR_W   = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mclk_rise,
  input  logic       strobe,
  input  logic       cfg_dbl,
  input  logic       cfg_cds,
  input  logic       cfg_direct,
  input  logic [1:0] cfg_width,
  input  logic [1:0] cfg_ftpos,
  output logic       dl_pulse,
  output logic       ft_pulse,
  output logic       pix_start,
  output logic       err_flag
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CTR_W-1:0] CTR_MAX = {CTR_W{1'b1}};

  logic [CNT_W-1:0] hi_cnt;
  logic [CTR_W-1:0] ctr, ctr_nx, per, hold_len, ft_from, ft_to;
  logic             locked, dl_q, strobe_d, ref_edge, illegal;

  assign per      = cfg_dbl ? CTR_W'(PIX_DBL) : CTR_W'(PIX_SGL);
  assign hold_len = cfg_dbl ? CTR_W'(cfg_width) + CTR_W'(1)
                            : CTR_W'({cfg_width, 1'b0}) + CTR_W'(2);
  assign ft_from  = cfg_dbl ? CTR_W'(cfg_ftpos) + CTR_W'(1)
                            : CTR_W'({cfg_ftpos, 1'b0}) + CTR_W'(2);
  assign ft_to    = ft_from + (cfg_dbl ? CTR_W'(1) : CTR_W'(2));

  assign ref_edge = mclk_rise && !strobe && (hi_cnt != '0);
  assign illegal  = cfg_dbl ? (hi_cnt > CNT_W'(1)) : (hi_cnt > CNT_W'(3));
  assign ctr_nx   = ref_edge ? '0 : ((ctr == CTR_MAX) ? ctr : ctr + CTR_W'(1));
  assign dl_pulse = cfg_direct ? strobe : dl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt    <= '0;
      ctr       <= '0;
      locked    <= 1'b0;
      dl_q      <= 1'b0;
      ft_pulse  <= 1'b0;
      strobe_d  <= 1'b0;
      pix_start <= 1'b0;
      err_flag  <= 1'b0;
    end else begin
      if (mclk_rise)
        hi_cnt <= !strobe ? '0 : ((hi_cnt == CNT_MAX) ? hi_cnt : hi_cnt + CNT_W'(1));
      ctr       <= ctr_nx;
      locked    <= locked | ref_edge;
      dl_q      <= locked && !ref_edge && (ctr_nx >= per - hold_len);
      ft_pulse  <= cfg_cds && locked && !ref_edge && (ctr_nx >= ft_from) && (ctr_nx < ft_to);
      strobe_d  <= strobe;
      pix_start <= cfg_direct ? (strobe_d && !strobe) : ref_edge;
      if (ref_edge)
        err_flag <= illegal;
      else if (ctr == per - CTR_W'(1))
        err_flag <= 1'b0;
    end
  end

  AST_FT_OFF_IN_DC: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_cds |=> !ft_pulse); // R7
  AST_PIX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_start |=> !pix_start); // R9
  AST_DL_FALL_AT_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_direct && $past(!cfg_direct) && $fell(dl_pulse)) |-> pix_start); // R1
  AST_FT_SGL_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_dbl && $rose(ft_pulse)) |=> ft_pulse); // R5
  AST_FT_DBL_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dbl && ft_pulse) |=> !ft_pulse); // R6
  AST_ERR_AT_REF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> $past(ref_edge)); // R8
endmodule

// File: tb/pixel_sample_pulse_gen_bench.sv
`timescale 1ns/1ps
module pixel_sample_pulse_gen_bench;
  logic clk = 1'b0, rst_n = 1'b0, mclk_rise = 1'b0, strobe = 1'b0;
  logic cfg_dbl = 1'b0, cfg_cds = 1'b0, cfg_direct = 1'b0;
  logic [1:0] cfg_width = '0, cfg_ftpos = '0;
  logic dl_pulse, ft_pulse, pix_start, err_flag;

  pixel_sample_pulse_gen u_pixel_sample_pulse_gen (
    .clk(clk), .rst_n(rst_n), .mclk_rise(mclk_rise), .strobe(strobe),
    .cfg_dbl(cfg_dbl), .cfg_cds(cfg_cds), .cfg_direct(cfg_direct),
    .cfg_width(cfg_width), .cfg_ftpos(cfg_ftpos),
    .dl_pulse(dl_pulse), .ft_pulse(ft_pulse), .pix_start(pix_start), .err_flag(err_flag));

  always #4 clk = ~clk;

  typedef struct packed {
    logic dbl, cds, dir;
    logic [1:0] w, pos;
    logic [2:0] n;
    logic [3:0] dlw, fts;
    logic [1:0] ftw;
    logic err;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 3'd1, 4'd2, 4'd0, 2'd0, 1'b0},
    '{1'b0, 1'b1, 1'b0, 2'd3, 2'd3, 3'd3, 4'd8, 4'd8, 2'd2, 1'b0},
    '{1'b0, 1'b1, 1'b0, 2'd1, 2'd1, 3'd2, 4'd4, 4'd4, 2'd2, 1'b0},
    '{1'b0, 1'b1, 1'b0, 2'd2, 2'd2, 3'd4, 4'd6, 4'd6, 2'd2, 1'b1},
    '{1'b1, 1'b1, 1'b0, 2'd0, 2'd0, 3'd1, 4'd1, 4'd1, 2'd1, 1'b0},
    '{1'b1, 1'b1, 1'b0, 2'd3, 2'd3, 3'd1, 4'd4, 4'd4, 2'd1, 1'b0},
    '{1'b1, 1'b0, 1'b0, 2'd1, 2'd2, 3'd2, 4'd2, 4'd0, 2'd0, 1'b1},
    '{1'b0, 1'b1, 1'b1, 2'd3, 2'd0, 3'd2, 4'd0, 4'd2, 2'd2, 1'b0},
    '{1'b1, 1'b1, 1'b1, 2'd2, 2'd1, 3'd1, 4'd0, 4'd2, 2'd1, 1'b0}
  };

  int checks = 0, fails = 0;
  int since_e = 0, per = 16, dlw = 2, fts = 0, ftw = 0;
  bit locked_m = 0, last_ill = 0, cur_ill = 0, pend_e = 0;

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0b expected=%0b (cycles since ref=%0d)", tag, act, exp, since_e);
    end
  endtask

  task automatic sample();
    logic e_dl, e_ft, e_err;
    string dtag;
    if (cfg_direct) begin
      e_dl = strobe; dtag = "R4 dl follows strobe";
    end else begin
      e_dl = locked_m && !pend_e && (since_e >= per - dlw);
      if (!locked_m) dtag = "R10 dl before first ref";
      else if (since_e >= per) dtag = "R11 dl held";
      else dtag = cfg_dbl ? "R1 R3 dl window" : "R1 R2 dl window";
    end
    e_ft  = cfg_cds && locked_m && (since_e >= fts) && (since_e < fts + ftw);
    e_err = locked_m && last_ill && (since_e <= per - 1);
    chk(dtag, dl_pulse, e_dl);
    chk(!cfg_cds ? "R7 ft in DC" : (cfg_dbl ? "R6 ft window" : "R5 ft window"), ft_pulse, e_ft);
    chk("R9 pix_start", pix_start, pend_e);
    chk("R8 err_flag", err_flag, e_err);
  endtask

  task automatic step(input logic s, input logic p, input bit e);
    @(negedge clk);
    sample();
    strobe = s;
    mclk_rise = p;
    if (e) begin
      since_e = 0; locked_m = 1; last_ill = cur_ill; pend_e = 1;
    end else begin
      since_e++; pend_e = 0;
    end
  endtask

  task automatic pixel(input int n);
    cur_ill = cfg_dbl ? (n >= 2) : (n >= 4);
    for (int u = 0; u < per; u++)
      step(u < 2 * n, (u % 2) == 0, (n > 0) && (u == 2 * n));
  endtask

  task automatic restart(input vec_t v);
    @(negedge clk);
    rst_n = 1'b0; strobe = 1'b0; mclk_rise = 1'b0;
    cfg_dbl = v.dbl; cfg_cds = v.cds; cfg_direct = v.dir;
    cfg_width = v.w; cfg_ftpos = v.pos;
    per = v.dbl ? 8 : 16; dlw = int'(v.dlw); fts = int'(v.fts); ftw = int'(v.ftw);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk("R10 reset dl", dl_pulse, 1'b0);
      chk("R10 reset ft", ft_pulse, 1'b0);
      chk("R10 reset pix", pix_start, 1'b0);
      chk("R10 reset err", err_flag, 1'b0);
    end
    rst_n = 1'b1;
    locked_m = 0; last_ill = 0; pend_e = 0; since_e = 1;
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < 9; k++) begin
      restart(VEC[k]);
      for (int p = 0; p < 4; p++) pixel(int'(VEC[k].n));
      step(1'b0, 1'b0, 1'b0);
    end
    // R11 and R8: late reference edge after a legal pixel, single-edge
    restart('{1'b0, 1'b1, 1'b0, 2'd1, 2'd0, 3'd1, 4'd4, 4'd2, 2'd2, 1'b0});
    pixel(1); pixel(1); pixel(5); pixel(0); pixel(0); pixel(1); pixel(1);
    // R8: double-edge violation lasts one 8-cycle pixel
    restart('{1'b1, 1'b0, 1'b0, 2'd2, 2'd0, 3'd1, 4'd3, 4'd0, 2'd0, 1'b0});
    pixel(1); pixel(2); pixel(0); pixel(0); pixel(1); pixel(1);
    step(1'b0, 1'b0, 1'b0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule